// File: doc/BRIEF.md
# Interleaved PCM to Subframe Word Packer

This block sits in an audio output path. It turns a stream of interleaved 24-bit PCM samples into 32-bit subframe words ready for a transmitter. The sample stream carries 2 to 8 channels. For each word the block adds three things: a channel-status bit taken from a programmed 32-bit consumer status word, an even-parity bit, and a block-start flag. It tracks its place in each 192-frame status block with a frame counter and a channel index.

A second mode handles source data that is already laid out as subframes, with flag bits on top, the sample in the middle and a preamble code in the low nibble. In this mode the block only moves fields into place. Both sides of the block use valid/ready handshakes. A registered output stage holds each word until the consumer takes it.

A one-cycle start pulse, or any change of configuration, puts the position back to channel 0 of frame 0.

Top module: `iec_subframe_packer`

## Requirements
- R1: In PCM mode (`cfg_passthru`=0), output bits 23..0 equal input bits 23..0. Input bits 31..24 are discarded. Output bits 31..29, 25 and 24 are 0.
- R2: Output bit 26 is the channel-status bit for the word's frame index f. For f < 32 it is bit f of `cfg_status` (bits 7..0 hold byte 0, least-significant bit first). For f ≥ 32 it is 0.
- R3: In PCM mode, output bit 27 makes the count of ones in output bits 27..0 even.
- R4: In PCM mode, output bit 28 is 1 only for channel 0 of frame 0. It is 0 on every other word.
- R5: The channel index counts 0 to N-1, with N = `cfg_channels` limited to the range 2..8 (values below 2 act as 2). After channel N-1 the frame index advances. The frame index wraps from 191 to 0.
- R6: For each channel c, status bits 23..20 are replaced by c+1 before the bit is chosen under R2.
- R7: With `cfg_passthru`=1, the output is the input shifted right by 4, with input bit 3 (the block-start preamble code) placed in output bit 28.
- R8: In a cycle where `start` is 1, or where `cfg_channels`, `cfg_passthru` or `cfg_status` differs from its value in the previous cycle, the position returns to channel 0, frame 0. A sample accepted in that same cycle is packed at channel 0, frame 0.
- R9: While `out_valid`=1 and `out_ready`=0, `out_data` stays stable and `in_ready` is 0. Every accepted sample appears exactly once, in order.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_channels | input | 4 | Channels per frame (2..8, clamped) |
| cfg_passthru | input | 1 | 1: re-pack preformatted subframes |
| cfg_status | input | 32 | Consumer channel-status word, byte 0 in bits 7..0 |
| start | input | 1 | Restart pulse for channel and frame position |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high with in_valid |
| in_data | input | 32 | Input sample or preformatted subframe |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer ready for output word |
| out_data | output | 32 | Packed subframe word |

## Verification
A position restart (a start pulse or a configuration change) can fall in the same cycle as the acceptance of a sample. The block must then pack that sample at channel 0 of frame 0, not at the old position. The bench fires random start pulses while input valid and output ready toggle randomly, so some pulses coincide with accepted samples. It judges such words against a model that zeroes its position before packing them. Such words must carry the block-start flag and the status bit of frame 0. Restarts that land during output stalls are also checked: the held word must not change.

// File: rtl/iec_pack_pkg.sv
package iec_pack_pkg;
   // Bit positions consumed by the downstream transmitter
   localparam int AUDIO_W   = 24;
   localparam int CS_BIT    = 26;
   localparam int PAR_BIT   = 27;
   localparam int BS_BIT    = 28;
   localparam int CHNUM_LSB = 20;
   localparam int WORD_W    = 32;

   function automatic logic even_fill(input logic [PAR_BIT-1:0] v);
      return ^v;
   endfunction
endpackage

// File: rtl/iec_pos_counter.sv
module iec_pos_counter #(
   parameter int CH_MAX = 8,
   parameter int FRAMES = 192,
   parameter int CHW    = 3,
   parameter int FRW    = 8,
   parameter int NW     = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           restart,
   input  logic           advance,
   input  logic [NW-1:0]  nch,
   output logic [CHW-1:0] cur_ch,
   output logic [FRW-1:0] cur_fr
);
   logic [CHW-1:0] ch_q;
   logic [FRW-1:0] fr_q;
   logic           last_ch;

   assign cur_ch  = restart ? '0 : ch_q;
   assign cur_fr  = restart ? '0 : fr_q;
   assign last_ch = (NW'(cur_ch) + NW'(1)) == nch;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ch_q <= '0;
         fr_q <= '0;
      end else if (advance) begin
         if (last_ch) begin
            ch_q <= '0;
            fr_q <= (cur_fr == FRW'(FRAMES - 1)) ? '0 : cur_fr + FRW'(1);
         end else begin
            ch_q <= cur_ch + CHW'(1);
            fr_q <= cur_fr;
         end
      end else if (restart) begin
         ch_q <= '0;
         fr_q <= '0;
      end
   end

   // R5: frame index never leaves the block
   a_r5_frame_range: assert property (@(posedge clk) disable iff (!rst_n)
      fr_q <= FRW'(FRAMES - 1));
   // R5: channel index stays below the active channel count
   a_r5_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
      !restart |-> (NW'(ch_q) < nch));
   // R8: an idle restart leaves the position at the origin
   a_r8_restart_origin: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && !advance) |=> (ch_q == '0 && fr_q == '0));
endmodule

// File: rtl/iec_status_sel.sv
module iec_status_sel
   import iec_pack_pkg::*;
#(
   parameter int STAT_BITS = 32,
   parameter int CHW       = 3,
   parameter int FRW       = 8
) (
   input  logic [STAT_BITS-1:0] status_word,
   input  logic [CHW-1:0]       ch,
   input  logic [FRW-1:0]       fr,
   output logic                 cs_bit
);
   localparam int SIW = $clog2(STAT_BITS);
   logic [STAT_BITS-1:0] per_chan;

   always_comb begin
      per_chan = status_word;
      per_chan[CHNUM_LSB +: 4] = 4'(ch) + 4'd1;
      cs_bit = (fr < FRW'(STAT_BITS)) ? per_chan[fr[SIW-1:0]] : 1'b0;
   end
endmodule

// File: rtl/iec_word_fmt.sv
module iec_word_fmt
   import iec_pack_pkg::*;
(
   input  logic              passthru,
   input  logic [WORD_W-1:0] din,
   input  logic              cs_bit,
   input  logic              blk_start,
   output logic [WORD_W-1:0] word
);
   logic [WORD_W-1:0] pcm_w;
   logic [WORD_W-1:0] pass_w;

   always_comb begin
      pcm_w = '0;
      pcm_w[AUDIO_W-1:0] = din[AUDIO_W-1:0];
      pcm_w[CS_BIT]      = cs_bit;
      pcm_w[BS_BIT]      = blk_start;
      pcm_w[PAR_BIT]     = even_fill(pcm_w[PAR_BIT-1:0]);

      pass_w         = din >> 4;
      pass_w[BS_BIT] = din[3];

      word = passthru ? pass_w : pcm_w;
   end
endmodule

// File: rtl/iec_subframe_packer.sv
module iec_subframe_packer
   import iec_pack_pkg::*;
#(
   parameter int CH_MAX    = 8,
   parameter int FRAMES    = 192,
   parameter int STAT_BITS = 32,
   localparam int NW  = $clog2(CH_MAX + 1),
   localparam int CHW = $clog2(CH_MAX),
   localparam int FRW = $clog2(FRAMES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NW-1:0]        cfg_channels,
   input  logic                 cfg_passthru,
   input  logic [STAT_BITS-1:0] cfg_status,
   input  logic                 start,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [WORD_W-1:0]    in_data,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic [WORD_W-1:0]    out_data
);
   localparam int CFG_W = NW + 1 + STAT_BITS;

   if (CH_MAX < 2 || CH_MAX > 15) begin : g_bad_chmax
      $error("CH_MAX must lie in 2..15");
   end
   if (STAT_BITS < CHNUM_LSB + 4 || STAT_BITS > FRAMES) begin : g_bad_stat
      $error("STAT_BITS must cover the channel nibble and fit in one block");
   end

   logic [CFG_W-1:0] cfg_now, cfg_q;
   logic             restart, accept, out_pass_q, cs_bit, blk_start;
   logic [NW-1:0]    nch;
   logic [CHW-1:0]   cur_ch;
   logic [FRW-1:0]   cur_fr;
   logic [WORD_W-1:0] word;

   assign cfg_now = {cfg_channels, cfg_passthru, cfg_status};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q <= '0;
      else        cfg_q <= cfg_now;
   end

   assign restart = start | (cfg_now != cfg_q);
   assign nch = (cfg_channels < NW'(2))      ? NW'(2)      :
                (cfg_channels > NW'(CH_MAX)) ? NW'(CH_MAX) : cfg_channels;

   assign in_ready = !out_valid || out_ready;
   assign accept   = in_valid && in_ready;

   iec_pos_counter #(.CH_MAX(CH_MAX), .FRAMES(FRAMES), .CHW(CHW), .FRW(FRW), .NW(NW)) u_pos (
      .clk(clk), .rst_n(rst_n), .restart(restart), .advance(accept),
      .nch(nch), .cur_ch(cur_ch), .cur_fr(cur_fr));

   iec_status_sel #(.STAT_BITS(STAT_BITS), .CHW(CHW), .FRW(FRW)) u_cs (
      .status_word(cfg_status), .ch(cur_ch), .fr(cur_fr), .cs_bit(cs_bit));

   assign blk_start = (cur_ch == '0) && (cur_fr == '0);

   iec_word_fmt u_fmt (
      .passthru(cfg_passthru), .din(in_data), .cs_bit(cs_bit),
      .blk_start(blk_start), .word(word));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_data   <= '0;
         out_pass_q <= 1'b0;
      end else if (accept) begin
         out_valid  <= 1'b1;
         out_data   <= word;
         out_pass_q <= cfg_passthru;
      end else if (out_ready) begin
         out_valid  <= 1'b0;
      end
   end

   // R9: a stalled word is held unchanged
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
   // R9: no sample is taken while the output is stalled
   a_r9_no_take: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);
   // R3: packed words carry even parity over bits 27..0
   a_r3_even: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_pass_q) |-> (^out_data[PAR_BIT:0] == 1'b0));
   // R1: unused fields of packed words stay clear
   a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_pass_q) |-> (out_data[31:29] == 3'b0 && out_data[25:24] == 2'b0));
endmodule

// File: tb/iec_subframe_packer_tb_top.sv
module iec_subframe_packer_tb_top;
   localparam int NW = 4;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [NW-1:0] cfg_channels;
   logic        cfg_passthru;
   logic [31:0] cfg_status;
   logic        start, in_valid, out_ready;
   logic [31:0] in_data;
   logic        in_ready, out_valid;
   logic [31:0] out_data;

   always #4 clk = ~clk;

   iec_subframe_packer dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_channels(cfg_channels),
      .cfg_passthru(cfg_passthru), .cfg_status(cfg_status), .start(start),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [31:0] q_word[$];
   bit          q_pass[$];
   string       q_cs_tag[$];
   string       q_bs_tag[$];

   int m_ch = 0;
   int m_fr = 0;
   logic [NW+32:0] prev_cfg;
   logic [NW-1:0]  nxt_ch;
   logic           nxt_pass;
   logic [31:0]    nxt_status;
   bit             hold_chk = 0;
   logic [31:0]    held_word;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int clampn(input int c);
      return (c < 2) ? 2 : ((c > 8) ? 8 : c);
   endfunction

   function automatic logic [31:0] model_word(input bit pass, input logic [31:0] d,
                                              input int ch, input int fr, input logic [31:0] st);
      logic [31:0] w, cs;
      if (pass) begin
         w = d >> 4;
         w[28] = d[3];
      end else begin
         cs = st;
         cs[23:20] = 4'(ch + 1);
         w = {8'h00, d[23:0]};
         w[26] = (fr < 32) ? cs[fr] : 1'b0;
         w[28] = (ch == 0 && fr == 0);
         w[27] = ^w[26:0];
      end
      return w;
   endfunction

   task automatic step(input int pv, input int pr, input int ps);
      bit restart;
      logic [31:0] w, e;
      @(negedge clk);
      if (hold_chk) begin
         chk("R9 stalled valid held", {31'b0, out_valid}, 32'd1);
         chk("R9 stalled data held", out_data, held_word);
      end
      cfg_channels = nxt_ch;
      cfg_passthru = nxt_pass;
      cfg_status   = nxt_status;
      in_valid  = ($urandom % 100) < pv;
      out_ready = ($urandom % 100) < pr;
      start     = ($urandom % 1000) < ps;
      in_data   = $urandom;
      #1;
      chk("R9 in_ready vs stall", {31'b0, in_ready}, {31'b0, (!out_valid || out_ready)});
      hold_chk  = out_valid && !out_ready;
      held_word = out_data;
      restart  = start || ({cfg_channels, cfg_passthru, cfg_status} != prev_cfg);
      prev_cfg = {cfg_channels, cfg_passthru, cfg_status};
      if (out_valid && out_ready) begin
         if (q_word.size() == 0) begin
            chk("R9 unexpected extra word", out_data, 32'hxxxx_xxxx);
         end else begin
            w = out_data;
            e = q_word.pop_front();
            if (q_pass.pop_front()) begin
               chk("R7 pass-through word", w, e);
               void'(q_cs_tag.pop_front());
               void'(q_bs_tag.pop_front());
            end else begin
               chk("R1 audio and clear fields", w & 32'hE3FF_FFFF, e & 32'hE3FF_FFFF);
               chk(q_cs_tag.pop_front(), {31'b0, w[26]}, {31'b0, e[26]});
               chk("R3 parity bit", {31'b0, w[27]}, {31'b0, e[27]});
               chk(q_bs_tag.pop_front(), {31'b0, w[28]}, {31'b0, e[28]});
            end
         end
      end
      if (restart) begin
         m_ch = 0;
         m_fr = 0;
      end
      if (in_valid && in_ready) begin
         q_word.push_back(model_word(cfg_passthru, in_data, m_ch, m_fr, cfg_status));
         q_pass.push_back(cfg_passthru);
         q_cs_tag.push_back((m_fr >= 20 && m_fr <= 23) ? "R6 channel number status bit"
                                                       : "R2 status bit");
         q_bs_tag.push_back(restart ? "R8 block start after restart"
                                    : "R4 R5 block start position");
         if (m_ch + 1 >= clampn(int'(cfg_channels))) begin
            m_ch = 0;
            m_fr = (m_fr == 191) ? 0 : m_fr + 1;
         end else begin
            m_ch++;
         end
      end
   endtask

   task automatic phase(input int nch, input bit pass, input int cycles,
                        input int pv, input int pr, input int ps);
      nxt_ch     = 4'(nch);
      nxt_pass   = pass;
      nxt_status = $urandom;
      for (int i = 0; i < cycles; i++) step(pv, pr, ps);
   endtask

   initial begin
      void'($urandom(32'h5EED_1234));
      rst_n = 1'b0;
      cfg_channels = 4'd2; cfg_passthru = 1'b0; cfg_status = 32'hA5C3_0F11;
      nxt_ch = 4'd2; nxt_pass = 1'b0; nxt_status = 32'hA5C3_0F11;
      prev_cfg = {cfg_channels, cfg_passthru, cfg_status};
      start = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_data = '0;
      repeat (3) @(negedge clk);
      chk("R10 reset out_valid", {31'b0, out_valid}, 32'd0);
      chk("R10 reset in_ready", {31'b0, in_ready}, 32'd1);
      rst_n = 1'b1;
      // directed: one full-throughput block at 2 channels
      for (int i = 0; i < 420; i++) step(100, 100, 0);
      phase(2, 0, 1500, 70, 60, 0);
      phase(5, 0, 2500, 80, 70, 0);
      phase(8, 0, 3000, 90, 80, 0);
      phase(0, 0, 900, 85, 75, 0);    // R5 clamp low
      phase(15, 0, 1800, 85, 75, 0);  // R5 clamp high
      phase(6, 1, 600, 70, 50, 0);    // R7
      phase(3, 0, 1500, 100, 100, 60); // R8 coincident restart
      phase(4, 0, 1500, 80, 50, 40);  // R8 restarts under stalls
      nxt_status = 32'hFFFF_FFFF;
      for (int i = 0; i < 500; i++) step(100, 100, 0);
      for (int i = 0; i < 20; i++) step(0, 100, 0);
      chk("R9 every sample emitted once", 32'(q_word.size()), 32'd0);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule